// File: doc/BRIEF.md
# DMA Channel Control Register and Condition Selectors

This block keeps the 16-bit control and status word of one descriptor-driven DMA channel. It also keeps three mask/value selectors, one each for the interrupt, branch and wait decisions. Software updates the control word with a masked write, so a single access changes only the bits it names. Hardware can set or clear the eight device-dependent status bits at any time. The command sequencer reports three things back into the word: that it is active, that it has died, and that a branch was taken.

Each selector is compared without pause against the low eight bits of the word. A condition is true when the status bits, ANDed with the selector's mask, equal the selector's value. The three results go straight to the command sequencer. Wake and flush requests written by software reach the sequencer as single-cycle pulses. The request bits stay readable until the sequencer acknowledges them.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous reset the control word and all three selectors are zero, so every condition output reads 1.
- R2: A write to address 0 carries a 16-bit mask in wr_data[31:16] and new values in wr_data[15:0]. Only masked bits among run (bit 15), pause (14), flush (13), wake (12) and device status (7:0) change. Bit positions in the word: run 15, pause 14, flush 13, wake 12, dead 11, active 10, bit 9 always 0, branch-taken 8, device status 7:0.
- R3: Software writes never change dead (11), active (10), branch-taken (8) or bit 9.
- R4: A write with mask bit 15 set and value bit 15 clear forces active and dead to 0 on the next cycle. This overrides any sequencer update made in the same cycle.
- R5: seq_active_upd loads active from seq_active_val, seq_dead_set sets dead, and seq_branch_upd loads branch-taken from seq_branch_val.
- R6: hw_dev_set forces device status bits to 1 and hw_dev_clr forces them to 0. Set wins over clear. A hardware update of a bit wins over a software write to that bit in the same cycle, and the write's other bits still apply.
- R7: A software write that sets wake (or flush) sets the bit and raises wake_pulse (or flush_pulse) for the one following cycle. wake_ack (flush_ack) clears the bit, unless a software write to that bit happens in the same cycle, in which case the write wins.
- R8: Addresses 1, 2 and 3 hold the interrupt, branch and wait selectors. A write loads the mask from wr_data[23:16] and the value from wr_data[7:0], and ignores the other bits. A read returns the same layout with zeros elsewhere.
- R9: int_cond, br_cond and wait_cond are 1 exactly when (device status AND mask) equals value for their selector. They follow register state with no extra delay. A value with bits outside the mask is never matched.
- R10: rd_data is combinational on rd_addr. Address 0 returns the control word in bits 15:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 interrupt, 2 branch, 3 wait selector |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 32 | Read data |
| hw_dev_set | input | 8 | Hardware set of device status bits |
| hw_dev_clr | input | 8 | Hardware clear of device status bits |
| seq_active_upd | input | 1 | Load the active bit |
| seq_active_val | input | 1 | New active value |
| seq_dead_set | input | 1 | Set the dead bit |
| seq_branch_upd | input | 1 | Load the branch-taken bit |
| seq_branch_val | input | 1 | New branch-taken value |
| wake_ack | input | 1 | Sequencer accepted the wake request |
| flush_ack | input | 1 | Sequencer accepted the flush request |
| wake_pulse | output | 1 | One-cycle wake request |
| flush_pulse | output | 1 | One-cycle flush request |
| int_cond | output | 1 | Interrupt selector condition |
| br_cond | output | 1 | Branch selector condition |
| wait_cond | output | 1 | Wait selector condition |

## Verification
Two kinds of same-cycle conflict are provoked on purpose. In the first, a software masked write to the device status bits meets hw_dev_set and hw_dev_clr on overlapping bits. In the second, a write that clears run meets a sequencer update of active or dead. Directed steps set up each collision with known literal results. A long random phase then makes these collisions, and ack-versus-write collisions on wake and flush, happen often. In every cycle, a behavioural reference model in the bench judges the read port, the pulses and the three conditions.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int DEV_W   = 8;
    localparam int REG_W   = 16;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int N_SEL   = 3;
    localparam int SEL_MASK_LSB = 16;
    localparam int RUN_BIT   = 15;
    localparam int FLUSH_BIT = 13;
    localparam int WAKE_BIT  = 12;
    // software may touch run, pause, flush, wake and the device status byte
    localparam logic [REG_W-1:0] SW_WRITE_MASK = {4'hF, 4'h0, {DEV_W{1'b1}}};

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_SEL_INT = 2'd1,
        A_SEL_BR = 2'd2,
        A_SEL_WAIT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic run;
        logic pause;
        logic flush;
        logic wake;
        logic dead;
        logic active;
        logic rsvd;
        logic br_taken;
        logic [DEV_W-1:0] dev;
    } ctrl_t;

    typedef struct packed {
        logic [DEV_W-1:0] mask;
        logic [DEV_W-1:0] value;
    } sel_t;

    function automatic logic sel_match(logic [DEV_W-1:0] dev, sel_t s);
        return (dev & s.mask) == s.value;
    endfunction

    function automatic logic [WORD_W-1:0] sel_pack(sel_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEL_MASK_LSB +: DEV_W] = s.mask;
        w[DEV_W-1:0] = s.value;
        return w;
    endfunction
endpackage

// File: rtl/dcc_status.sv
module dcc_status
    import dcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_mask,
    input  logic [REG_W-1:0] sw_val,
    input  logic [DEV_W-1:0] hw_set,
    input  logic [DEV_W-1:0] hw_clr,
    input  logic             seq_active_upd,
    input  logic             seq_active_val,
    input  logic             seq_dead_set,
    input  logic             seq_branch_upd,
    input  logic             seq_branch_val,
    input  logic             wake_ack,
    input  logic             flush_ack,
    output ctrl_t            ctrl_q,
    output logic             wake_pulse,
    output logic             flush_pulse
);
    logic [REG_W-1:0] eff_mask;
    ctrl_t            sw_next;
    ctrl_t            nxt;
    logic             run_clr;
    logic             wake_wr;
    logic             flush_wr;

    always_comb begin
        eff_mask = sw_we ? (sw_mask & SW_WRITE_MASK) : '0;
        sw_next  = ctrl_t'((ctrl_q & ~eff_mask) | (sw_val & eff_mask));
        run_clr  = eff_mask[RUN_BIT] & ~sw_val[RUN_BIT];
        wake_wr  = eff_mask[WAKE_BIT];
        flush_wr = eff_mask[FLUSH_BIT];
        nxt = sw_next;
        if (wake_ack && !wake_wr)   nxt.wake  = 1'b0;
        if (flush_ack && !flush_wr) nxt.flush = 1'b0;
        if (run_clr) begin
            nxt.active = 1'b0;
            nxt.dead   = 1'b0;
        end else begin
            if (seq_active_upd) nxt.active = seq_active_val;
            if (seq_dead_set)   nxt.dead   = 1'b1;
        end
        if (seq_branch_upd) nxt.br_taken = seq_branch_val;
        // hardware beats software; set beats clear
        nxt.dev  = (sw_next.dev & ~hw_clr) | hw_set;
        nxt.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            wake_pulse  <= 1'b0;
            flush_pulse <= 1'b0;
        end else begin
            ctrl_q      <= nxt;
            wake_pulse  <= wake_wr & sw_val[WAKE_BIT];
            flush_pulse <= flush_wr & sw_val[FLUSH_BIT];
        end
    end

    p_hw_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((ctrl_q.dev & $past(hw_set)) == $past(hw_set)));

    p_hw_clr_r6: assert property (@(posedge clk) disable iff (rst)
        ((hw_clr & ~hw_set) != '0) |=> ((ctrl_q.dev & $past(hw_clr & ~hw_set)) == '0));

    p_run_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (sw_we && sw_mask[RUN_BIT] && !sw_val[RUN_BIT]) |=> (!ctrl_q.active && !ctrl_q.dead));

    p_locked_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !seq_active_upd && !seq_dead_set && !seq_branch_upd
         && !(sw_mask[RUN_BIT] && !sw_val[RUN_BIT]))
        |=> ($stable(ctrl_q.active) && $stable(ctrl_q.dead) && $stable(ctrl_q.br_taken)));

    p_dead_set_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_dead_set && !(sw_we && sw_mask[RUN_BIT] && !sw_val[RUN_BIT])) |=> ctrl_q.dead);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wake_ack && !(sw_we && sw_mask[WAKE_BIT])) |=> (!ctrl_q.wake && !wake_pulse));

    p_rsvd_low_r2: assert property (@(posedge clk) disable iff (rst) !ctrl_q.rsvd);
endmodule

// File: rtl/dcc_sel.sv
module dcc_sel
    import dcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  sel_t             wsel,
    input  logic [DEV_W-1:0] dev,
    output sel_t             sel_q,
    output logic             cond
);
    always_ff @(posedge clk) begin
        if (rst)     sel_q <= '0;
        else if (we) sel_q <= wsel;
    end

    assign cond = sel_match(dev, sel_q);

    p_sel_load_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> (sel_q == $past(wsel)));

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(sel_q));

    p_value_outside_mask_r9: assert property (@(posedge clk) disable iff (rst)
        ((sel_q.value & ~sel_q.mask) != '0) |-> !cond);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [DEV_W-1:0]  hw_dev_set,
    input  logic [DEV_W-1:0]  hw_dev_clr,
    input  logic              seq_active_upd,
    input  logic              seq_active_val,
    input  logic              seq_dead_set,
    input  logic              seq_branch_upd,
    input  logic              seq_branch_val,
    input  logic              wake_ack,
    input  logic              flush_ack,
    output logic              wake_pulse,
    output logic              flush_pulse,
    output logic              int_cond,
    output logic              br_cond,
    output logic              wait_cond
);
    ctrl_t            ctrl;
    sel_t             sels  [N_SEL];
    logic [N_SEL-1:0] conds;
    sel_t             wsel;

    assign wsel.mask  = wr_data[SEL_MASK_LSB +: DEV_W];
    assign wsel.value = wr_data[DEV_W-1:0];

    dcc_status u_status (
        .clk            (clk),
        .rst            (rst),
        .sw_we          (wr_en && (wr_addr == A_CTRL)),
        .sw_mask        (wr_data[WORD_W-1:REG_W]),
        .sw_val         (wr_data[REG_W-1:0]),
        .hw_set         (hw_dev_set),
        .hw_clr         (hw_dev_clr),
        .seq_active_upd (seq_active_upd),
        .seq_active_val (seq_active_val),
        .seq_dead_set   (seq_dead_set),
        .seq_branch_upd (seq_branch_upd),
        .seq_branch_val (seq_branch_val),
        .wake_ack       (wake_ack),
        .flush_ack      (flush_ack),
        .ctrl_q         (ctrl),
        .wake_pulse     (wake_pulse),
        .flush_pulse    (flush_pulse)
    );

    for (genvar k = 0; k < N_SEL; k++) begin : g_sel
        dcc_sel u_sel (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && (wr_addr == ADDR_W'(k + 1))),
            .wsel  (wsel),
            .dev   (ctrl.dev),
            .sel_q (sels[k]),
            .cond  (conds[k])
        );
    end

    assign int_cond  = conds[0];
    assign br_cond   = conds[1];
    assign wait_cond = conds[2];

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_CTRL:     rd_data = {{(WORD_W-REG_W){1'b0}}, ctrl};
            A_SEL_INT:  rd_data = sel_pack(sels[0]);
            A_SEL_BR:   rd_data = sel_pack(sels[1]);
            default:    rd_data = sel_pack(sels[2]);
        endcase
    end

    p_reset_conds_r1: assert property (@(posedge clk)
        $past(rst) |-> (int_cond && br_cond && wait_cond));

    p_rd_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_CTRL) |-> (rd_data[WORD_W-1:REG_W] == '0));
endmodule

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  hw_dev_set = '0;
    logic [7:0]  hw_dev_clr = '0;
    logic        seq_active_upd = 1'b0, seq_active_val = 1'b0, seq_dead_set = 1'b0;
    logic        seq_branch_upd = 1'b0, seq_branch_val = 1'b0;
    logic        wake_ack = 1'b0, flush_ack = 1'b0;
    logic        wake_pulse, flush_pulse, int_cond, br_cond, wait_cond;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_chan_ctl uut (.*);

    // behavioural reference model
    bit       m_run, m_pause, m_flush, m_wake, m_dead, m_active, m_br;
    bit [7:0] m_dev;
    bit [7:0] m_smask [3];
    bit [7:0] m_sval  [3];
    bit       m_wp, m_fp;

    always @(posedge clk) begin
        if (rst) begin
            {m_run, m_pause, m_flush, m_wake, m_dead, m_active, m_br, m_wp, m_fp} = '0;
            m_dev = 0;
            for (int i = 0; i < 3; i++) begin m_smask[i] = 0; m_sval[i] = 0; end
        end else begin
            bit [15:0] mk, vl;
            bit sw, clr_run;
            sw = wr_en && wr_addr == 0;
            mk = sw ? wr_data[31:16] : 16'h0;
            vl = wr_data[15:0];
            clr_run = mk[15] && !vl[15];
            if (mk[15]) m_run = vl[15];
            if (mk[14]) m_pause = vl[14];
            if (mk[13]) m_flush = vl[13]; else if (flush_ack) m_flush = 0;
            if (mk[12]) m_wake = vl[12];  else if (wake_ack) m_wake = 0;
            m_fp = mk[13] && vl[13];
            m_wp = mk[12] && vl[12];
            if (clr_run) begin m_active = 0; m_dead = 0; end
            else begin
                if (seq_active_upd) m_active = seq_active_val;
                if (seq_dead_set) m_dead = 1;
            end
            if (seq_branch_upd) m_br = seq_branch_val;
            for (int i = 0; i < 8; i++) begin
                if (hw_dev_set[i]) m_dev[i] = 1;
                else if (hw_dev_clr[i]) m_dev[i] = 0;
                else if (mk[i]) m_dev[i] = vl[i];
            end
            if (wr_en && wr_addr != 0) begin
                m_smask[wr_addr-1] = wr_data[23:16];
                m_sval[wr_addr-1]  = wr_data[7:0];
            end
        end
    end

    function automatic bit [31:0] m_read(bit [1:0] a);
        if (a == 0)
            return {16'h0, m_run, m_pause, m_flush, m_wake, m_dead, m_active, 1'b0, m_br, m_dev};
        return {8'h0, m_smask[a-1], 8'h0, m_sval[a-1]};
    endfunction

    function automatic bit m_cond(int k);
        return (m_dev & m_smask[k]) == m_sval[k];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all;
        check("R10 rd_data vs model", rd_data, m_read(rd_addr));
        check("R9 int_cond vs model", {31'h0, int_cond}, {31'h0, m_cond(0)});
        check("R9 br_cond vs model", {31'h0, br_cond}, {31'h0, m_cond(1)});
        check("R9 wait_cond vs model", {31'h0, wait_cond}, {31'h0, m_cond(2)});
        check("R7 wake_pulse vs model", {31'h0, wake_pulse}, {31'h0, m_wp});
        check("R7 flush_pulse vs model", {31'h0, flush_pulse}, {31'h0, m_fp});
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
        compare_all();
    endtask

    task automatic idle;
        wr_en = 0; hw_dev_set = 0; hw_dev_clr = 0;
        seq_active_upd = 0; seq_dead_set = 0; seq_branch_upd = 0;
        wake_ack = 0; flush_ack = 0;
    endtask

    task automatic wr(bit [1:0] a, bit [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst = 1;
        tick(); tick();
        rst = 0;
        rd_addr = 0;
        #1;
        // R1 reset state
        check("R1 ctrl after reset", rd_data, 32'h0);
        check("R1 conds after reset", {29'h0, int_cond, br_cond, wait_cond}, 32'h7);

        // R2 masked write
        wr(0, 32'hF0FF_C0A5); tick(); idle();
        check("R2 masked write", rd_data, 32'h0000_C0A5);
        wr(0, 32'h0003_0000); tick(); idle();
        check("R2 partial mask clears two bits", rd_data, 32'h0000_C0A4);

        // R3 locked bits
        wr(0, 32'h0F00_0F00); tick(); idle();
        check("R3 locked bits unchanged", rd_data, 32'h0000_C0A4);

        // R5 sequencer updates
        seq_active_upd = 1; seq_active_val = 1; seq_dead_set = 1;
        seq_branch_upd = 1; seq_branch_val = 1;
        tick(); idle();
        check("R5 sequencer status", rd_data, 32'h0000_CDA4);

        // R4 run clear beats sequencer
        wr(0, 32'h8000_0000); seq_active_upd = 1; seq_active_val = 1; seq_dead_set = 1;
        tick(); idle();
        check("R4 run clear", rd_data, 32'h0000_41A4);

        // R6 hardware vs software collision
        wr(0, 32'h00FF_0080); hw_dev_set = 8'h05; hw_dev_clr = 8'h84;
        tick(); idle();
        check("R6 hw wins", rd_data, 32'h0000_4105);

        // R7 wake pulse and ack
        wr(0, 32'h1000_1000); tick(); idle();
        check("R7 wake pulse", {31'h0, wake_pulse}, 32'h1);
        check("R7 wake bit set", rd_data, 32'h0000_5105);
        tick();
        check("R7 pulse is one cycle", {31'h0, wake_pulse}, 32'h0);
        check("R7 wake bit held", rd_data, 32'h0000_5105);
        wake_ack = 1; tick(); idle();
        check("R7 ack clears wake", rd_data, 32'h0000_4105);
        wr(0, 32'h2000_2000); flush_ack = 1; tick(); idle();
        check("R7 write beats ack", rd_data, 32'h0000_6105);
        check("R7 flush pulse", {31'h0, flush_pulse}, 32'h1);

        // R8 selector layout
        wr(1, 32'hFF0F_FF03); rd_addr = 1; tick(); idle();
        check("R8 selector readback", rd_data, 32'h000F_0003);
        check("R9 int mismatch", {31'h0, int_cond}, 32'h0);
        hw_dev_clr = 8'h04; hw_dev_set = 8'h02; tick(); idle();
        check("R9 int match", {31'h0, int_cond}, 32'h1);
        wr(2, 32'h0001_0002); rd_addr = 2; tick(); idle();
        check("R9 value outside mask", {31'h0, br_cond}, 32'h0);
        check("R8 branch selector readback", rd_data, 32'h0001_0002);

        // random phase against model
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            if (r < 35) wr(2'($urandom_range(0, 3)), $urandom());
            if ($urandom_range(0, 3) == 0) hw_dev_set = 8'($urandom() & $urandom());
            if ($urandom_range(0, 3) == 0) hw_dev_clr = 8'($urandom());
            seq_active_upd = ($urandom_range(0, 4) == 0);
            seq_active_val = 1'($urandom());
            seq_dead_set   = ($urandom_range(0, 6) == 0);
            seq_branch_upd = ($urandom_range(0, 4) == 0);
            seq_branch_val = 1'($urandom());
            wake_ack  = ($urandom_range(0, 3) == 0);
            flush_ack = ($urandom_range(0, 3) == 0);
            rd_addr = 2'($urandom_range(0, 3));
            tick();
        end
        idle();
        tick();
        done = 1;
        summary();
    end
endmodule